// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block is the digital half of a transmit automatic level control loop. It keeps a 5-bit attenuation code for an external variable-gain output stage. It moves that code by at most one step per control period, based on two comparators that watch the fed-back output amplitude. One comparator reports an amplitude above a high threshold and the other reports an amplitude above a low threshold. The analog stage, the comparators and the threshold references sit outside the block.

Each control period has two parts. A settling blank comes first and lets the output stage settle after a gain change. A peak-detect window follows, and `peak_window` is high for its whole length. The block collects comparator events only inside the window. At the end of the period it decides on one of three outcomes:

- Attenuate one step more if the amplitude ever crossed the high threshold.
- Attenuate one step less if the amplitude never reached the low threshold.
- Otherwise hold the code.

With the defaults, a 11.0592 MHz clock gives a 7200 Hz update rate: 384 settling cycles (about 34.7 µs) and 1152 detect cycles (about 104.2 µs). Code 0 means 0 dB. Each code step adds about 0.84 dB of attenuation, so code 31 is about -26 dB.

Top module: `tx_level_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `gain_code` is 31 (maximum attenuation) and `peak_window` is 0.
- R2: Counting from the first cycle `tx_en` is high, each period has SETTLE_CYC cycles with `peak_window` at 0, then DETECT_CYC cycles with it at 1, and then the next period starts.
- R3: If `cmp_above_hi` was 1 in any detect cycle of a period, `gain_code` rises by one on the clock edge that ends that period.
- R4: If neither comparator was 1 in any detect cycle of a period, `gain_code` falls by one on the clock edge that ends that period.
- R5: If `cmp_above_lo` was 1 in some detect cycle and `cmp_above_hi` in none, `gain_code` keeps its value.
- R6: A high-threshold event outranks a low-threshold event in the same period: the code rises by one.
- R7: Comparator values during the settling cycles have no effect on the decision.
- R8: The code saturates: a rise at 31 leaves 31, a fall at 0 leaves 0, and it never wraps.
- R9: While `tx_en` is 0, `peak_window` is 0, comparators are ignored and `gain_code` becomes 31 on the next edge. A new rise of `tx_en` restarts the period at its first settling cycle.
- R10: `gain_code` changes by at most one step per clock, and while `tx_en` stays high it changes only on the edge after a cycle with `peak_window` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_en | input | 1 | Transmit active; low holds the loop idle at maximum attenuation |
| cmp_above_hi | input | 1 | Comparator: feedback amplitude above the high threshold |
| cmp_above_lo | input | 1 | Comparator: feedback amplitude above the low threshold |
| gain_code | output | GAIN_W | Attenuation code, 0 = 0 dB, each step about 0.84 dB more |
| peak_window | output | 1 | High during the peak-detect part of each period |

## Verification
The bound checker watches four properties on every cycle. The code never moves by more than one step in a cycle. It never changes outside a period boundary while transmit stays on. The idle state forces maximum attenuation. The window stays closed while transmit is off. Only the bench scenarios can show the decision rules, because those depend on comparator events collected over a whole window. These rules are the priority of high over low, the blindness during settling, events caught in the final detect cycle, saturation at both ends, and the restart of the period after transmit is toggled.

// File: rtl/tx_level_pkg.sv
package tx_level_pkg;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_DETECT = 1'b1
  } phase_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_t;

endpackage

// File: rtl/tx_level_timer.sv
module tx_level_timer
  import tx_level_pkg::*;
#(
  parameter int SETTLE_CYC = 384,
  parameter int DETECT_CYC = 1152
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  output phase_t phase,
  output logic   period_end
);

  localparam int PERIOD = SETTLE_CYC + DETECT_CYC;
  localparam int CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST_CNT   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] DETECT_BEG = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!run)                cnt_d = '0;
    else if (cnt_q == LAST_CNT) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    phase      = (run && cnt_q >= DETECT_BEG) ? PH_DETECT : PH_SETTLE;
    period_end = run && (cnt_q == LAST_CNT);
  end

endmodule

// File: rtl/tx_level_peak.sv
module tx_level_peak
  import tx_level_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  sample,
  input  logic  above_hi,
  input  logic  above_lo,
  output step_t decision
);

  logic hi_q, lo_q;
  logic hi_now, lo_now;
  logic hi_d, lo_d;

  always_comb begin
    hi_now = hi_q | (sample & above_hi);
    lo_now = lo_q | (sample & above_lo);
    hi_d   = clr ? 1'b0 : hi_now;
    lo_d   = clr ? 1'b0 : lo_now;
    if (hi_now)       decision = STEP_UP;
    else if (!lo_now) decision = STEP_DOWN;
    else              decision = STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

endmodule

// File: rtl/tx_level_gain.sv
module tx_level_gain
  import tx_level_pkg::*;
#(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              apply,
  input  step_t             step,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] MAX_CODE = {GAIN_W{1'b1}};

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              gain_en;

  always_comb begin
    gain_en = !run || apply;
    gain_d  = gain_q;
    if (!run) begin
      gain_d = MAX_CODE;
    end else if (step == STEP_UP && gain_q != MAX_CODE) begin
      gain_d = gain_q + 1'b1;
    end else if (step == STEP_DOWN && gain_q != '0) begin
      gain_d = gain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= MAX_CODE;
    else if (gain_en) gain_q <= gain_d;
  end

  assign gain = gain_q;

endmodule

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl
  import tx_level_pkg::*;
#(
  parameter int SETTLE_CYC = 384,
  parameter int DETECT_CYC = 1152,
  parameter int GAIN_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cmp_above_hi,
  input  logic              cmp_above_lo,
  output logic [GAIN_W-1:0] gain_code,
  output logic              peak_window
);

  phase_t phase;
  logic   period_end;
  step_t  decision;

  tx_level_timer #(
    .SETTLE_CYC(SETTLE_CYC),
    .DETECT_CYC(DETECT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tx_en),
    .phase     (phase),
    .period_end(period_end)
  );

  tx_level_peak u_peak (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (period_end | ~tx_en),
    .sample  (phase == PH_DETECT),
    .above_hi(cmp_above_hi),
    .above_lo(cmp_above_lo),
    .decision(decision)
  );

  tx_level_gain #(
    .GAIN_W(GAIN_W)
  ) u_gain (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tx_en),
    .apply(period_end),
    .step (decision),
    .gain (gain_code)
  );

  assign peak_window = (phase == PH_DETECT);

endmodule

// File: rtl/tx_level_ctrl_chk.sv
module tx_level_ctrl_chk #(
  parameter int GAIN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic [GAIN_W-1:0] gain,
  input logic              win
);

  localparam logic [GAIN_W-1:0] MAX_CODE = {GAIN_W{1'b1}};

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en)) |-> ({1'b0, gain} == {1'b0, $past(gain)} ||
                                 {1'b0, gain} == {1'b0, $past(gain)} + 1'b1 ||
                                 {1'b0, gain} + 1'b1 == {1'b0, $past(gain)})); // R10

  AST_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && gain != $past(gain)) |-> $past(win)); // R10

  AST_IDLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (gain == MAX_CODE)); // R9

  AST_IDLE_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !win); // R9

endmodule

bind tx_level_ctrl tx_level_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .tx_en(tx_en),
  .gain (gain_code),
  .win  (peak_window)
);

// File: tb/tx_level_ctrl_test.sv
module tx_level_ctrl_test;

  localparam int S  = 4;
  localparam int D  = 6;
  localparam int P  = S + D;
  localparam int GW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic          hi = 1'b0;
  logic          lo = 1'b0;
  logic [GW-1:0] gain;
  logic          win;

  int checks = 0;
  int errors = 0;
  int exp_gain = 31;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tx_level_ctrl #(.SETTLE_CYC(S), .DETECT_CYC(D), .GAIN_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cmp_above_hi(hi), .cmp_above_lo(lo),
    .gain_code(gain), .peak_window(win)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int delta(input int mode);
    case (mode)
      0: return -1;
      2, 4, 6: return 1;
      3: return -1;
      default: return 0;
    endcase
  endfunction

  // Starts in cycle 0 of a period (just after a negedge), ends in cycle 0 of the next.
  task automatic period(input int mode, input string req);
    for (int i = 0; i < P; i++) begin
      bit w = (i >= S);
      bit last = (i == P - 1);
      check("R2 window", int'(win), int'(w));
      if (i == S) check({req, " code held mid-period"}, int'(gain), exp_gain);
      case (mode)
        0: begin hi = 0;       lo = 0;       end
        1: begin hi = 0;       lo = w;       end
        2: begin hi = (i == S + 1); lo = 1;  end
        3: begin hi = !w;      lo = !w;      end
        4: begin hi = last;    lo = 0;       end
        5: begin hi = 0;       lo = last;    end
        default: begin hi = w; lo = w;       end
      endcase
      @(negedge clk);
    end
    hi = 0; lo = 0;
    exp_gain = exp_gain + delta(mode);
    if (exp_gain > 31) exp_gain = 31;
    if (exp_gain < 0)  exp_gain = 0;
    check(req, int'(gain), exp_gain);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(gain), 31);
    check("R1 reset window", int'(win), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(gain), 31);
    check("R1 window after release", int'(win), 0);
    tx_en = 1'b1;
    period(1, "R5 hold on low event");
    period(2, "R8 rise saturates at 31");
    for (int k = 0; k < 31; k++) period(0, "R4 fall on quiet window");
    period(0, "R8 fall saturates at 0");
    period(2, "R3 rise on high event");
    period(6, "R6 high outranks low");
    period(4, "R3 high in last detect cycle");
    period(5, "R5 low in last detect cycle holds");
    period(3, "R7 settling events ignored");
    period(1, "R5 hold");
    // drop transmit partway through a period
    for (int i = 0; i < 3; i++) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      hi = 1; lo = (i == 1);
      check("R9 idle code max", int'(gain), 31);
      check("R9 idle window low", int'(win), 0);
      @(negedge clk);
    end
    hi = 0; lo = 0;
    check("R9 idle code after comparator activity", int'(gain), 31);
    exp_gain = 31;
    tx_en = 1'b1;
    period(0, "R9 period restarts on transmit rise");
    for (int k = 0; k < 3; k++) period(2, "R8 rise to top");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule